// File: doc/BRIEF.md
# Fractional Clock-Enable Divider Bank

This block paces four execution engines. Each engine has its own divider. A divider emits a one-cycle enable pulse on `tick`, and the spacing between pulses follows a divisor with a 16-bit whole part and an 8-bit fractional part. When the divisor has a fractional part, the divider adds it to an 8-bit accumulator once per output period. Whenever that addition carries, the period grows by one clock. Over time the average spacing equals the programmed divisor, and the jitter pattern depends only on the divisor and the phase at which the divider was started.

The dividers never stop. The per-engine run bits in the control word only drive the `run_en` outputs and have no effect on the dividers. A restart strobe in the control word resets each selected divider's counter and accumulator to phase zero on the write edge. Dividers that share a divisor and are restarted in one write therefore pulse in exact lockstep from then on. A divisor can be rewritten while its divider runs. The new value governs the period that starts at the next pulse, and software can issue a restart to resynchronise several dividers after such a change.

Access is through a single-cycle write port and a combinational read port. Address 0 holds the control word. Addresses 1 to 4 hold the divisors of dividers 0 to 3.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, the control word reads 0 and every divisor reads 0x000100, which is whole part 1 and fraction 0.
- R2: A divisor with whole part N of 2 or more and fraction 0 produces one pulse every N clocks, with no pulse in the clock after a pulse.
- R3: With a non-zero fraction F, each period lasts the whole part plus the carry out of an 8-bit accumulator that gains F at every pulse. The accumulator starts at 0 after a restart, and the first pulse comes in the first cycle after the restart edge.
- R4: A whole part of 0 counts as 65536 clocks.
- R5: A divisor written while a divider runs does not shorten or stretch the period in progress. It first applies to the period that begins at the next pulse.
- R6: Control bits [7:4] are restart strobes, with bit 4+k acting on divider k. Every selected divider pulses in the first cycle after the write edge, and dividers that are not selected keep their phase.
- R7: The restart strobes are self-clearing, so bits [7:4] of the control word always read 0.
- R8: Control bits [3:0] are run bits, with bit k driving `run_en[k]`. They are read/write, they change only when the control word is written, and changing them neither stops nor shifts any divider.
- R9: Reserved bits read 0. These are control bits [31:8], divisor bits [31:24], and all bits of addresses 5 to 7. Writes to them have no effect.
- R10: A divisor of exactly 1.0 (whole 1, fraction 0) produces a pulse on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 3 | Register address: 0 control, 1..4 divisors |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| run_en | output | 4 | Per-engine run bits |
| tick | output | 4 | Per-divider one-cycle enable pulses |

## Verification
The bench follows each pulse train cycle by cycle against an accumulator model for several divisors. These include 1.0, pure integers, halves and a fraction of 1/256, so an accumulator that is dropped, seeded wrongly or checked for carry off by one shows up as a pulse in the wrong cycle. The bench restarts two dividers that had different phases and confirms they pulse together. At the same time it confirms that a third divider which was not selected keeps its own phase, which catches restart strobes applied to the wrong lane or applied one cycle late. A divisor rewritten mid-period must leave the old period intact, so a design that reloads at once would pulse early. A whole part of 0 must give a 65536-clock gap rather than a continuous pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int NUM_DIV     = 4;
    localparam int INT_W       = 16;
    localparam int FRAC_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 32;
    localparam int DIV_W       = INT_W + FRAC_W;
    localparam int CNT_W       = INT_W + 1;
    localparam int RUN_LSB     = 0;
    localparam int RESTART_LSB = NUM_DIV;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } divisor_t;

    localparam divisor_t DIV_RESET = '{whole: INT_W'(1), frac: '0};

    // Whole part as a clock count; zero stands for the full 2^INT_W range.
    function automatic logic [CNT_W-1:0] whole_cycles(input logic [INT_W-1:0] w);
        return (w == '0) ? CNT_W'(1) << INT_W : CNT_W'(w);
    endfunction

    function automatic logic [ADDR_W-1:0] div_addr(input int k);
        return ADDR_W'(k + 1);
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    output logic [NUM_DIV-1:0]                run_q,
    output logic [NUM_DIV-1:0]                restart,
    output divisor_t [NUM_DIV-1:0]            div_q
);

    logic ctrl_wr;

    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);

    // Restart strobe is live only during the write cycle; it is never stored.
    assign restart = ctrl_wr ? wdata[RESTART_LSB +: NUM_DIV] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (ctrl_wr) begin
            run_q <= wdata[RUN_LSB +: NUM_DIV];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_DIV; k++) begin
                div_q[k] <= DIV_RESET;
            end
        end else if (wr_en) begin
            for (int k = 0; k < NUM_DIV; k++) begin
                if (addr == div_addr(k)) begin
                    div_q[k] <= divisor_t'(wdata[DIV_W-1:0]);
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[RUN_LSB +: NUM_DIV] = run_q;
        end
        for (int k = 0; k < NUM_DIV; k++) begin
            if (addr == div_addr(k)) begin
                rdata[DIV_W-1:0] = div_q[k];
            end
        end
    end

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  divisor_t div,
    output logic     tick
);

    logic [CNT_W-1:0]  remain_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [CNT_W-1:0]  next_remain;

    assign tick = (remain_q == '0);

    always_comb begin
        acc_sum     = {1'b0, acc_q} + {1'b0, div.frac};
        next_remain = whole_cycles(div.whole) + CNT_W'(acc_sum[FRAC_W]) - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            remain_q <= '0;
            acc_q    <= '0;
        end else if (tick) begin
            remain_q <= next_remain;
            acc_q    <= acc_sum[FRAC_W-1:0];
        end else begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_DIV-1:0]  run_en,
    output logic [NUM_DIV-1:0]  tick
);

    logic [NUM_DIV-1:0]     restart_pulse;
    divisor_t [NUM_DIV-1:0] div_q;

    clkdiv_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .run_q   (run_en),
        .restart (restart_pulse),
        .div_q   (div_q)
    );

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_lane
        clkdiv_lane i_lane (
            .clk     (clk),
            .rst     (rst),
            .restart (restart_pulse[k]),
            .div     (div_q[k]),
            .tick    (tick[k])
        );
    end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
    import clkdiv_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W-1:0]      rdata,
    input logic [NUM_DIV-1:0]     run_en,
    input logic [NUM_DIV-1:0]     tick,
    input logic [NUM_DIV-1:0]     restart_pulse,
    input divisor_t [NUM_DIV-1:0] div_q
);

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_chk
        AST_RESTART_PHASE0: assert property (@(posedge clk) disable iff (rst)
            restart_pulse[k] |=> tick[k]); // R6

        AST_NO_EARLY_TICK: assert property (@(posedge clk) disable iff (rst)
            (tick[k] && !restart_pulse[k] && div_q[k].whole != INT_W'(1)) |=> !tick[k]); // R2

        AST_UNIT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
            (tick[k] && div_q[k].whole == INT_W'(1) && div_q[k].frac == '0) |=> tick[k]); // R10
    end

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_CTRL) |=> $stable(run_en)); // R8

    AST_RESTART_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_CTRL) |-> rdata[RESTART_LSB +: NUM_DIV] == '0); // R7

    AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_CTRL) |-> rdata[DATA_W-1:RESTART_LSB+NUM_DIV] == '0); // R9

    AST_DIV_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:DIV_W] == '0); // R9

endmodule

bind clkdiv_bank clkdiv_bank_chk i_chk (.*);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
    import clkdiv_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic [NUM_DIV-1:0] run_en;
    logic [NUM_DIV-1:0] tick;

    int n_tests = 0;
    int n_fail  = 0;
    longint cyc = 0;

    clkdiv_bank i_clkdiv_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .run_en(run_en), .tick(tick)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // whole part [23:8], fraction [7:0]
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h000100, 24'h000200, 24'h000300, 24'h000280,
        24'h000340, 24'h000155, 24'h0005FF, 24'h000401
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Write; returns at the sample point just after the write edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = '0;
    endtask

    // Follows lane k from the restart sample point against the accumulator model.
    task automatic follow(input int k, input logic [23:0] d, input int ncyc,
                          input string req, input bit poke_run);
        int nxt = 0;
        int acc = 0;
        int bad = -1;
        int whole = (d[23:8] == 0) ? 65536 : int'(d[23:8]);
        bit exp_t;
        bit act_t = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            exp_t = (c == nxt);
            if (exp_t) begin
                acc = acc + int'(d[7:0]);
                nxt = nxt + whole + (acc >> 8);
                acc = acc & 255;
            end
            if (tick[k] !== exp_t && bad < 0) begin
                bad = c; act_t = tick[k];
            end
            if (poke_run && c == 5) begin
                wr_en = 1'b1; addr = ADDR_CTRL; wdata = 32'h0000_000A;
            end
            if (poke_run && c == 6) begin
                wr_en = 1'b0; wdata = '0;
            end
            @(negedge clk);
        end
        check(bad < 0, req, $sformatf("lane %0d divisor 0x%06h pulse at cycle %0d", k, d, bad),
              longint'(act_t), longint'(!act_t));
    endtask

    initial begin
        #(150000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(ADDR_CTRL, r);
        check(r == 0, "R1", "control after reset", r, 0);
        rd(3'd1, r);
        check(r == 32'h0000_0100, "R1", "divisor after reset", r, 32'h100);
        // R10 divisor 1.0 pulses every clock
        for (int i = 0; i < 3; i++) begin
            check(tick == 4'hF, "R10", "ticks with divisor 1.0", tick, 4'hF);
            @(negedge clk);
        end

        // R3 / R2 / R10 vector table against accumulator model
        for (int v = 0; v < NVEC; v++) begin
            wr(div_addr(v % NUM_DIV), {8'h00, VEC[v]});
            wr(ADDR_CTRL, 32'(1 << (RESTART_LSB + v % NUM_DIV)));
            follow(v % NUM_DIV, VEC[v], 600, "R3", 1'b0);
        end

        // R8 run bits change mid-stream without disturbing the divider
        wr(div_addr(0), 32'h0000_0300);
        wr(ADDR_CTRL, 32'h0000_0010);
        follow(0, 24'h000300, 40, "R8", 1'b1);
        check(run_en == 4'hA, "R8", "run_en after write", run_en, 4'hA);
        rd(ADDR_CTRL, r);
        check(r == 32'hA, "R8", "run bits read back", r, 32'hA);

        // R7 / R9 reserved and self-clearing bits
        wr(ADDR_CTRL, 32'hFFFF_FFF5);
        rd(ADDR_CTRL, r);
        check(r == 32'h5, "R7", "control read after all-ones write", r, 32'h5);
        wr(div_addr(1), 32'hFFFF_FFFF);
        rd(div_addr(1), r);
        check(r == 32'h00FF_FFFF, "R9", "divisor reserved bits", r, 32'h00FF_FFFF);
        rd(3'd5, r);
        check(r == 0, "R9", "unused address reads zero", r, 0);

        // R6 lockstep after a joint restart; unselected lane keeps phase
        begin
            longint t3;
            int nxt = 0, acc = 0, bad_ls = -1, bad_m = -1, bad_3 = -1;
            bit exp_t;
            wr(div_addr(1), 32'h0000_0280);
            repeat (3) @(negedge clk);
            wr(div_addr(2), 32'h0000_0280);
            wr(div_addr(3), 32'h0000_0700);
            wr(ADDR_CTRL, 32'h0000_0080);
            t3 = cyc;
            repeat (2) @(negedge clk);
            wr(ADDR_CTRL, 32'h0000_0060);
            for (int c = 0; c < 500; c++) begin
                exp_t = (c == nxt);
                if (exp_t) begin
                    acc = acc + 128;
                    nxt = nxt + 2 + (acc >> 8);
                    acc = acc & 255;
                end
                if (tick[1] !== tick[2] && bad_ls < 0) bad_ls = c;
                if (tick[1] !== exp_t && bad_m < 0) bad_m = c;
                if (tick[3] !== (((cyc - t3) % 7) == 0) && bad_3 < 0) bad_3 = c;
                @(negedge clk);
            end
            check(bad_ls < 0, "R6", "lanes 1 and 2 lockstep (first mismatch cycle)", bad_ls, -1);
            check(bad_m < 0, "R6", "lane 1 phase after restart (first mismatch cycle)", bad_m, -1);
            check(bad_3 < 0, "R6", "unselected lane 3 phase (first mismatch cycle)", bad_3, -1);
        end

        // R5 divisor change mid-period takes effect at the next pulse
        begin
            int bad = -1;
            bit exp_t;
            wr(div_addr(0), 32'h0000_0A00);
            wr(ADDR_CTRL, 32'h0000_0010);
            for (int c = 0; c < 26; c++) begin
                exp_t = (c == 0) || (c >= 10 && ((c - 10) % 4) == 0);
                if (tick[0] !== exp_t && bad < 0) bad = c;
                if (c == 3) begin wr_en = 1'b1; addr = div_addr(0); wdata = 32'h0000_0400; end
                if (c == 4) begin wr_en = 1'b0; addr = '0; wdata = '0; end
                @(negedge clk);
            end
            check(bad < 0, "R5", "on-the-fly divisor pulse schedule (first mismatch cycle)", bad, -1);
        end

        // R4 whole part 0 means 65536
        begin
            int gap = 0;
            wr(div_addr(0), 32'h0000_0000);
            wr(ADDR_CTRL, 32'h0000_0010);
            check(tick[0] == 1'b1, "R4", "pulse right after restart", tick[0], 1);
            @(negedge clk);
            gap = 1;
            while (tick[0] !== 1'b1 && gap < 70000) begin
                @(negedge clk);
                gap++;
            end
            check(gap == 65536, "R4", "gap for whole part 0", gap, 65536);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule